// File: doc/BRIEF.md
# Accumulator Round and Saturate Unit

This block turns the contents of two accumulators into a rounded, saturated 32-bit signed value. The whole first accumulator is joined with the low half of a second accumulator to form a 56-bit signed operand. That operand is shifted left or right by a signed amount, rounded at bit 15, and reduced to a 44-bit intermediate. The intermediate is then clamped to the signed 32-bit range, and the result is delivered as a 16-bit high word and a 16-bit low word for a register pair.

The arithmetic is purely combinational. A single-cycle `start` strobe loads the result into the output registers. On the same edge it updates two flags: an overflow flag that shows whether the last operation clamped, and a history flag that keeps the overflow flag's previous value. Instruction decode and the register file are outside this block.

Top module: `acc_round_sat`

## Requirements
- R1: While `rst` is high at a clock edge, `pair_hi_o`, `pair_lo_o`, `ovf_o` and `ovf_hist_o` all become 0.
- R2: The operand is `{acc_main_i, acc_low_i}`. `acc_main_i` (40 bits) occupies operand bits 55:16 and `acc_low_i` occupies bits 15:0. The operand is read as signed, with bit 55 (that is, `acc_main_i[39]`) as its sign.
- R3: `shift_i` is a 6-bit two's-complement amount and is clamped to the range -16..+16. A non-negative amount shifts the operand left. A negative amount shifts it arithmetically right by the magnitude.
- R4: 0x8000 is added to the shifted value, which is then arithmetically shifted right by 16. Only bits 43:0 of that result are kept, as a signed 44-bit intermediate; any higher bits are dropped, so the value wraps.
- R5: If the intermediate is above +0x7FFFFFFF, the outputs become `pair_hi_o` = 0x7FFF and `pair_lo_o` = 0xFFFF, and `ovf_o` is set.
- R6: If the intermediate is below -0x80000000, the outputs become `pair_hi_o` = 0x8000 and `pair_lo_o` = 0x0000, and `ovf_o` is set.
- R7: Otherwise, `pair_hi_o` takes intermediate bits 31:16, `pair_lo_o` takes bits 15:0, and `ovf_o` is cleared.
- R8: On every strobe, `ovf_hist_o` takes the value `ovf_o` held just before that strobe, whether or not the operation clamps.
- R9: The outputs change only on a clock edge where `start` is high; they are updated on that edge. With `start` low, the outputs hold whatever the inputs do.
- R10: With `ovf_o` clear, `acc_main_i` = 0x80_0000_0000, any `acc_low_i` and a shift of -2 give 0x8000/0x0000 with `ovf_o` = 1 and `ovf_hist_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that loads the result and updates the flags |
| acc_main_i | input | 40 | First accumulator (guard, high and low fields) |
| acc_low_i | input | 16 | Low half of the second accumulator |
| shift_i | input | 6 | Signed shift amount |
| pair_hi_o | output | 16 | Result high word (even register) |
| pair_lo_o | output | 16 | Result low word (odd register) |
| ovf_o | output | 1 | Overflow from the last operation |
| ovf_hist_o | output | 1 | Previous overflow value |

## Verification
The bench builds the unit with its default widths: a 40-bit accumulator, a 6-bit shift code clamped at 16 and a 44-bit intermediate. At those widths, every shift code from -20 to +20 can be applied to each of several dozen operand patterns. The patterns mix hand-picked boundary values with pseudo-random ones. This sweep reaches both clamp edges, the rounding carry at bit 15, the clamp zone of the shift code and the wrap of oversized left shifts inside the 44-bit intermediate. All of these are predicted with 128-bit arithmetic in the bench.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_POS  = 2'd1,
    SAT_NEG  = 2'd2
  } sat_kind_e;
endpackage

// File: rtl/ars_operand.sv
module ars_operand #(
  parameter int ACC_W  = 40,
  parameter int HALF_W = 16,
  parameter int WORK_W = 60
) (
  input  logic [ACC_W-1:0]         acc_main_i,
  input  logic [HALF_W-1:0]        acc_low_i,
  output logic signed [WORK_W-1:0] operand_o
);
  localparam int OP_W  = ACC_W + HALF_W;
  localparam int EXT_W = WORK_W - OP_W;

  // R2: join the accumulators, then sign-extend from the top operand bit
  logic [OP_W-1:0] joined;
  assign joined    = {acc_main_i, acc_low_i};
  assign operand_o = {{EXT_W{joined[OP_W-1]}}, joined};
endmodule

// File: rtl/ars_shifter.sv
module ars_shifter #(
  parameter int WORK_W    = 60,
  parameter int SHIFT_W   = 6,
  parameter int MAX_SHIFT = 16
) (
  input  logic signed [WORK_W-1:0]  value_i,
  input  logic signed [SHIFT_W-1:0] amount_i,
  output logic signed [WORK_W-1:0]  value_o
);
  localparam int MAG_W = $clog2(MAX_SHIFT + 1);
  localparam logic signed [SHIFT_W-1:0] LIM_P = SHIFT_W'(MAX_SHIFT);
  localparam logic signed [SHIFT_W-1:0] LIM_N = -SHIFT_W'(MAX_SHIFT);

  logic signed [SHIFT_W-1:0] clamped;
  logic signed [SHIFT_W-1:0] abs_amt;
  logic                      go_left;
  logic [MAG_W-1:0]          mag;

  // R3: clamp the code, then split it into a direction and a magnitude
  always_comb begin
    if (amount_i > LIM_P)      clamped = LIM_P;
    else if (amount_i < LIM_N) clamped = LIM_N;
    else                       clamped = amount_i;
  end

  assign go_left = !clamped[SHIFT_W-1];
  assign abs_amt = go_left ? clamped : -clamped;
  assign mag     = MAG_W'(abs_amt);

  // one stage per magnitude bit (logarithmic shifter)
  logic signed [WORK_W-1:0] stage [0:MAG_W];
  assign stage[0] = value_i;

  for (genvar k = 0; k < MAG_W; k++) begin : g_stage
    assign stage[k+1] = !mag[k] ? stage[k]
                      : (go_left ? (stage[k] <<< (2**k)) : (stage[k] >>> (2**k)));
  end

  assign value_o = stage[MAG_W];
endmodule

// File: rtl/ars_limiter.sv
module ars_limiter
  import ars_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int INT_W  = 44,
  parameter int WORK_W = 60
) (
  input  logic signed [WORK_W-1:0] shifted_i,
  output logic [2*HALF_W-1:0]      result_o,
  output sat_kind_e                kind_o
);
  localparam int RES_W = 2 * HALF_W;
  localparam logic signed [WORK_W-1:0] ROUND_C = WORK_W'(1) <<< (HALF_W - 1);
  localparam logic signed [INT_W-1:0] TOP_LIM =
    {{(INT_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] BOT_LIM =
    {{(INT_W-RES_W+1){1'b1}}, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] POS_CODE = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG_CODE = {1'b1, {(RES_W-1){1'b0}}};

  logic signed [WORK_W-1:0] rounded;
  logic signed [WORK_W-1:0] scaled;
  logic signed [INT_W-1:0]  inter;

  // R4: round at the half-word boundary, then keep a wrapped INT_W window
  assign rounded = shifted_i + ROUND_C;
  assign scaled  = rounded >>> HALF_W;
  assign inter   = INT_W'(scaled);

  // R5 R6 R7: clamp to the result range
  always_comb begin
    if (inter > TOP_LIM) begin
      kind_o   = SAT_POS;
      result_o = POS_CODE;
    end else if (inter < BOT_LIM) begin
      kind_o   = SAT_NEG;
      result_o = NEG_CODE;
    end else begin
      kind_o   = SAT_NONE;
      result_o = inter[RES_W-1:0];
    end
  end
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat
  import ars_pkg::*;
#(
  parameter int ACC_W     = 40,
  parameter int HALF_W    = 16,
  parameter int INT_W     = 44,
  parameter int SHIFT_W   = 6,
  parameter int MAX_SHIFT = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ACC_W-1:0]          acc_main_i,
  input  logic [HALF_W-1:0]         acc_low_i,
  input  logic signed [SHIFT_W-1:0] shift_i,
  output logic [HALF_W-1:0]         pair_hi_o,
  output logic [HALF_W-1:0]         pair_lo_o,
  output logic                      ovf_o,
  output logic                      ovf_hist_o
);
  localparam int WORK_W = INT_W + HALF_W;
  localparam int RES_W  = 2 * HALF_W;

  logic signed [WORK_W-1:0] operand;
  logic signed [WORK_W-1:0] shifted;
  logic [RES_W-1:0]         result;
  sat_kind_e                kind;

  ars_operand #(.ACC_W(ACC_W), .HALF_W(HALF_W), .WORK_W(WORK_W)) u_operand (
    .acc_main_i(acc_main_i),
    .acc_low_i (acc_low_i),
    .operand_o (operand)
  );

  ars_shifter #(.WORK_W(WORK_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)) u_shifter (
    .value_i (operand),
    .amount_i(shift_i),
    .value_o (shifted)
  );

  ars_limiter #(.HALF_W(HALF_W), .INT_W(INT_W), .WORK_W(WORK_W)) u_limiter (
    .shifted_i(shifted),
    .result_o (result),
    .kind_o   (kind)
  );

  // R1 R8 R9: output registers loaded only on the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_hi_o  <= '0;
      pair_lo_o  <= '0;
      ovf_o      <= 1'b0;
      ovf_hist_o <= 1'b0;
    end else if (start) begin
      pair_hi_o  <= result[RES_W-1:HALF_W];
      pair_lo_o  <= result[HALF_W-1:0];
      ovf_o      <= (kind != SAT_NONE);
      ovf_hist_o <= ovf_o;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable({pair_hi_o, pair_lo_o, ovf_o, ovf_hist_o}));

  p_history_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> ovf_hist_o == $past(ovf_o));

  p_pos_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (start && kind == SAT_POS) |=>
      ({pair_hi_o, pair_lo_o} == {1'b0, {(RES_W-1){1'b1}}}) && ovf_o);

  p_neg_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (start && kind == SAT_NEG) |=>
      ({pair_hi_o, pair_lo_o} == {1'b1, {(RES_W-1){1'b0}}}) && ovf_o);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (start && kind == SAT_NONE) |=> !ovf_o);

  p_ovf_code_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ({pair_hi_o, pair_lo_o} == {1'b0, {(RES_W-1){1'b1}}}) ||
              ({pair_hi_o, pair_lo_o} == {1'b1, {(RES_W-1){1'b0}}}));
endmodule

// File: tb/acc_round_sat_bench.sv
module acc_round_sat_bench;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [39:0]       acc_main = '0;
  logic [15:0]       acc_low = '0;
  logic signed [5:0] shift = '0;
  logic [15:0]       pair_hi, pair_lo;
  logic              ovf, ovf_hist;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic exp_ovf_prev = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  acc_round_sat u_acc_round_sat (
    .clk(clk), .rst(rst), .start(start),
    .acc_main_i(acc_main), .acc_low_i(acc_low), .shift_i(shift),
    .pair_hi_o(pair_hi), .pair_lo_o(pair_lo),
    .ovf_o(ovf), .ovf_hist_o(ovf_hist)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected value from the requirements: class 0 none, 1 high clamp, 2 low clamp
  function automatic void model(input logic [39:0] a, input logic [15:0] b,
                                input int s, output logic [31:0] res, output int cls);
    logic signed [127:0] op;
    logic signed [127:0] sv;
    logic signed [43:0]  it;
    int n;
    n  = (s > 16) ? 16 : ((s < -16) ? -16 : s);
    op = {{72{a[39]}}, a, b};
    sv = (n >= 0) ? (op <<< n) : (op >>> (-n));
    sv = sv + 128'sh8000;
    sv = sv >>> 16;
    it = sv[43:0];
    if (it > 44'sd2147483647) begin
      res = 32'h7FFF_FFFF; cls = 1;
    end else if (it < -44'sd2147483648) begin
      res = 32'h8000_0000; cls = 2;
    end else begin
      res = it[31:0]; cls = 0;
    end
  endfunction

  task automatic run_op(input logic [39:0] a, input logic [15:0] b, input int s,
                        input string note);
    logic [31:0] res;
    int cls;
    string tag;
    model(a, b, s, res, cls);
    @(negedge clk);
    acc_main = a; acc_low = b; shift = 6'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tag = (cls == 1) ? "R5" : ((cls == 2) ? "R6" : "R7");
    chk({tag, " R2 R3 R4 pair ", note}, {pair_hi, pair_lo}, res);
    chk({tag, " flag ", note}, {31'd0, ovf}, {31'd0, cls != 0});
    chk({"R8 history ", note}, {31'd0, ovf_hist}, {31'd0, exp_ovf_prev});
    exp_ovf_prev = (cls != 0);
  endtask

  function automatic logic [55:0] pattern(input int i);
    case (i)
      0:  return {40'h00_0000_0000, 16'h0000};
      1:  return {40'h80_0000_0000, 16'h5000};
      2:  return {40'h00_7FFF_FFFF, 16'hFFFF};
      3:  return {40'h00_8000_0000, 16'h0000};
      4:  return {40'hFF_8000_0000, 16'h0000};
      5:  return {40'hFF_7FFF_FFFF, 16'hFFFF};
      6:  return {40'hFF_FFFF_FFFF, 16'h8000};
      7:  return {40'h00_0000_0000, 16'h8000};
      8:  return {40'h00_0000_0000, 16'h7FFF};
      9:  return {40'h7F_FFFF_FFFF, 16'hFFFF};
      10: return {40'h00_0000_7FFF, 16'hFFFF};
      11: return {40'hFF_FFFF_8000, 16'h0000};
      12: return {40'h00_0000_0001, 16'h0000};
      13: return {40'h00_7FFF_FFFF, 16'h7FFF};
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pair", {pair_hi, pair_lo}, 32'h0);
    chk("R1 reset flags", {30'd0, ovf, ovf_hist}, 32'h0);
    rst = 1'b0;

    // R4: rounding carry at bit 15
    run_op(40'h0, 16'h8000, 0, "round up");
    run_op(40'h0, 16'h7FFF, 0, "round down");
    run_op(40'hFF_FFFF_FFFF, 16'h8000, 0, "round negative half");

    // R10: corner case from a clear overflow flag
    run_op(40'h0, 16'h0, 0, "clear");
    run_op(40'h80_0000_0000, 16'h5000, -2, "R10 corner");
    chk("R10 corner pair", {pair_hi, pair_lo}, 32'h8000_0000);
    chk("R10 corner flags", {30'd0, ovf, ovf_hist}, 32'h2);
    run_op(40'h80_0000_0000, 16'h5000, -2, "R10 repeat");
    chk("R8 history after clamp", {31'd0, ovf_hist}, 32'h1);

    // R9: inputs move with start low, outputs hold
    begin
      logic [33:0] snap;
      snap = {pair_hi, pair_lo, ovf, ovf_hist};
      @(negedge clk);
      acc_main = 40'h12_3456_789A; acc_low = 16'h1234; shift = 6'sd3;
      @(negedge clk);
      acc_main = 40'hFF_0000_0001; shift = -6'sd7;
      @(negedge clk);
      chk("R9 hold pair", {pair_hi, pair_lo}, snap[33:2]);
      chk("R9 hold flags", {30'd0, ovf, ovf_hist}, {30'd0, snap[1:0]});
    end

    // R2 R3 R4 R5 R6 R7: sweep shift codes over fixed patterns
    for (int p = 0; p < 14; p++) begin
      for (int s = -20; s <= 20; s++) begin
        logic [55:0] v;
        v = pattern(p);
        run_op(v[55:16], v[15:0], s, $sformatf("pat %0d shift %0d", p, s));
      end
    end

    // pseudo-random operands over all shift codes, incl. R3 clamp zone
    for (int r = 0; r < 40; r++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      for (int s = -20; s <= 20; s++) begin
        run_op({rng[63:56] & {8{r[0]}} | {8{r[1] & rng[39]}}, rng[31:0]},
               rng[47:32], s, $sformatf("rnd %0d shift %0d", r, s));
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule